// File: doc/BRIEF.md
# Multi-Tone Quadrature Lock-In Demodulator

This block takes a stream of signed ADC samples and demodulates it against several reference tones at the same time. Each tone has its own phase accumulator, which drives a sine and cosine lookup. Each tone also has its own pair of multipliers and its own accumulate-and-dump low-pass stage. Every tone reports an in-phase and a quadrature sum at the end of each integration window, together with a one-cycle valid strobe.

The typical use is with an undersampled input. There, the fundamental and its harmonics fold to different, known baseband frequencies. For example, a 10.7 MHz signal sampled at 2 Msps lands at 700 kHz, its second harmonic at 600 kHz and its third harmonic at 100 kHz. Programming one tone to each of these apparent frequencies separates the three responses in one pass.

The references are true sampled sinusoids rather than square waves, so odd harmonics of a reference give no response. A small write port loads the per-tone frequency words and the shared window length.

Top module: `lockin_multitone`

## Requirements
- R1: After reset, the block is in its default state.
  - Every result is zero, every valid strobe is low and every phase accumulator is zero.
  - Every active and pending frequency word is zero.
  - The window length is 16 samples.
- R2: For an accepted sample, each tone forms two products from its phase `p` (the top 10 bits of its 32-bit phase accumulator). The sine reference is `S(p) = round(32767*sin(2*pi*(p+0.5)/1024))`, with rounding half away from zero.
  - In-phase product: the sample times the cosine reference `S((p+256) mod 1024)`.
  - Quadrature product: the sample times `S(p)`.
- R3: Each accepted sample advances a tone's phase by its active frequency word, modulo 2^32. The phase does not move in cycles where `smp_valid` is low.
- R4: When N samples have been accepted in a window, the results hold the sums of that window's products as 40-bit two's complement values (wrapping on overflow). The sums then restart from zero for the next window.
- R5: `res_valid` goes high for every tone together in the cycle after the clock edge that accepts the window's last sample. Otherwise it is low, and the results hold their values.
- R6: A write with `cfg_addr` = k (k < 3) stores a pending frequency word for tone k.
  - The tone keeps using its old word up to and including the window's last sample.
  - At that boundary the pending word becomes active, and the tone's phase restarts at zero.
- R7: A write with `cfg_addr` = 3 sets the window length N from `cfg_wdata[15:0]`, and it takes effect at once.
  - A window ends on the sample that brings its count to N, or on the next sample if the count is already at or past N.
  - A write of zero is ignored.
- R8: The tones are independent. Three different frequency words, such as 0x5999999A, 0x4CCCCCCD and 0x0CCCCCCD, each produce their own sums from the same samples.
- R9: With N = 1, every accepted sample ends a window, so back-to-back samples give back-to-back valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 16 | Signed input sample |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 2 | 0 to 2: tone frequency word; 3: window length |
| cfg_wdata | input | 32 | Write data |
| res_i | output | 120 | In-phase sums, tone k in bits [40k+39:40k] |
| res_q | output | 120 | Quadrature sums, tone k in bits [40k+39:40k] |
| res_valid | output | 3 | Per-tone result strobe |

## Verification
The bench goes after the points where a window boundary meets other events, and the failure each one would expose:
- A frequency word written in the middle of a window. A design that applies it at once, or that keeps the old phase, would give wrong sums for both that window and the next.
- A window length shrunk below the running count. A design that tests only for equality would never dump.
- Samples with idle gaps between them. A free-running phase would shift the references.
- A full-scale window that overflows 40 bits. This exposes missing sign extension or truncation of the products.
- Windows of length one, and a write of zero to the length. Such designs would skip strobes or stall.

// File: rtl/lockin_pkg.sv
// Package: shared helpers for the lock-in demodulator.
// Holds the constant function that builds the quarter-wave sine table.
package lockin_pkg;

    // Quarter-wave table entry k of qn, sampled at half-step offsets, scaled by amp.
    function automatic int quarter_sine(int k, int qn, int amp);
        real ang;
        ang = 3.14159265358979323846 / 2.0 * (real'(k) + 0.5) / real'(qn);
        return $rtoi(real'(amp) * $sin(ang) + 0.5);
    endfunction

endpackage

// File: rtl/lockin_sine_lut.sv
// Sine/cosine reference lookup.
// Takes the phase index (the top LUT_AW bits of an accumulator). Returns signed
// sine and cosine values that are folded out of a quarter-wave table.
// Assumes LUT_AW >= 3. The cosine index is the phase index plus a quarter turn.
module lockin_sine_lut #(
    parameter int LUT_AW = 10,
    parameter int SINE_W = 16
) (
    input  logic [LUT_AW-1:0]        phase_idx,
    output logic signed [SINE_W-1:0] sin_o,
    output logic signed [SINE_W-1:0] cos_o
);
    localparam int QN  = 2 ** (LUT_AW - 2);
    localparam int AMP = 2 ** (SINE_W - 1) - 1;
    localparam logic [LUT_AW-1:0] QUARTER = LUT_AW'(QN);

    logic signed [SINE_W-1:0] qtab [QN];

    // Quarter-wave magnitude table, one entry per generate step.
    for (genvar g = 0; g < QN; g++) begin : g_tab
        assign qtab[g] = SINE_W'(lockin_pkg::quarter_sine(g, QN, AMP));
    end

    logic [LUT_AW-1:0] cos_idx;
    logic [LUT_AW-3:0] s_addr, c_addr;
    logic signed [SINE_W-1:0] s_mag, c_mag;

    // Fold both indexes onto the quarter table and apply the half-turn sign.
    always_comb begin
        cos_idx = phase_idx + QUARTER;
        s_addr  = phase_idx[LUT_AW-2] ? ~phase_idx[LUT_AW-3:0] : phase_idx[LUT_AW-3:0];
        c_addr  = cos_idx[LUT_AW-2]   ? ~cos_idx[LUT_AW-3:0]   : cos_idx[LUT_AW-3:0];
        s_mag   = qtab[s_addr];
        c_mag   = qtab[c_addr];
        sin_o   = phase_idx[LUT_AW-1] ? -s_mag : s_mag;
        cos_o   = cos_idx[LUT_AW-1]   ? -c_mag : c_mag;
    end
endmodule

// File: rtl/lockin_window_ctl.sv
// Integration window controller.
// Counts accepted samples and flags the sample that closes each window.
// The length register is writable at any time; a zero write is dropped.
// The compare is greater-or-equal, so shrinking the length mid-window ends the
// window on the next sample.
module lockin_window_ctl #(
    parameter int CNT_W   = 16,
    parameter int DEF_LEN = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_valid,
    input  logic             len_we,
    input  logic [CNT_W-1:0] len_data,
    output logic             win_end
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;

    // Last sample of the window: the count has reached length minus one.
    assign win_end = smp_valid && (cnt >= len - 1'b1);

    // Track the window position and hold the programmed length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            len <= CNT_W'(DEF_LEN);
        end else begin
            if (len_we && len_data != '0)
                len <= len_data;
            if (smp_valid)
                cnt <= win_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/lockin_tone.sv
// One demodulation channel.
// Contains a phase accumulator with a double-buffered frequency word, the
// sine/cosine lookup, the I/Q multipliers and the accumulate-and-dump sums.
// Assumes win_end is only high together with smp_valid. A pending frequency
// word is applied, with the phase reset to zero, at the window boundary.
module lockin_tone #(
    parameter int SAMPLE_W = 16,
    parameter int PHASE_W  = 32,
    parameter int LUT_AW   = 10,
    parameter int SINE_W   = 16,
    parameter int ACC_W    = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic                       win_end,
    input  logic                       freq_we,
    input  logic [PHASE_W-1:0]         freq_data,
    output logic signed [ACC_W-1:0]    res_i,
    output logic signed [ACC_W-1:0]    res_q,
    output logic                       res_valid
);
    localparam int PROD_W = SAMPLE_W + SINE_W;

    logic [PHASE_W-1:0] phase, freq_act, freq_pend;
    logic               pend;
    logic signed [SINE_W-1:0] ref_sin, ref_cos;
    logic signed [PROD_W-1:0] prod_i, prod_q;
    logic signed [ACC_W-1:0]  ext_i, ext_q, acc_i, acc_q;

    lockin_sine_lut #(.LUT_AW(LUT_AW), .SINE_W(SINE_W)) u_lut (
        .phase_idx (phase[PHASE_W-1 -: LUT_AW]),
        .sin_o     (ref_sin),
        .cos_o     (ref_cos)
    );

    // Mix the sample with both references and sign-extend to sum width.
    always_comb begin
        prod_i = smp_data * ref_cos;
        prod_q = smp_data * ref_sin;
        ext_i  = {{(ACC_W-PROD_W){prod_i[PROD_W-1]}}, prod_i};
        ext_q  = {{(ACC_W-PROD_W){prod_q[PROD_W-1]}}, prod_q};
    end

    // Phase stepping, frequency hand-over, accumulation and dump.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= '0;
            freq_act  <= '0;
            freq_pend <= '0;
            pend      <= 1'b0;
            acc_i     <= '0;
            acc_q     <= '0;
            res_i     <= '0;
            res_q     <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (freq_we) begin
                freq_pend <= freq_data;
                pend      <= 1'b1;
            end
            if (smp_valid) begin
                if (win_end) begin
                    res_i     <= acc_i + ext_i;
                    res_q     <= acc_q + ext_q;
                    res_valid <= 1'b1;
                    acc_i     <= '0;
                    acc_q     <= '0;
                    if (pend) begin
                        freq_act <= freq_pend;
                        phase    <= '0;
                        if (!freq_we)
                            pend <= 1'b0;
                    end else begin
                        phase <= phase + freq_act;
                    end
                end else begin
                    acc_i <= acc_i + ext_i;
                    acc_q <= acc_q + ext_q;
                    phase <= phase + freq_act;
                end
            end
        end
    end
endmodule

// File: rtl/lockin_multitone.sv
// Multi-tone quadrature lock-in demodulator (top).
// Decodes configuration writes and runs one shared window controller.
// Instantiates NUM_TONES independent demodulation channels on the same stream.
// Address map: 0..NUM_TONES-1 select tone frequency words; NUM_TONES selects
// the window length.
module lockin_multitone #(
    parameter int NUM_TONES = 3,
    parameter int SAMPLE_W  = 16,
    parameter int PHASE_W   = 32,
    parameter int LUT_AW    = 10,
    parameter int SINE_W    = 16,
    parameter int ACC_W     = 40,
    parameter int CNT_W     = 16,
    parameter int DEF_LEN   = 16,
    parameter int ADDR_W    = $clog2(NUM_TONES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_data,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [PHASE_W-1:0]         cfg_wdata,
    output logic [NUM_TONES*ACC_W-1:0] res_i,
    output logic [NUM_TONES*ACC_W-1:0] res_q,
    output logic [NUM_TONES-1:0]       res_valid
);
    localparam logic [ADDR_W-1:0] LEN_ADDR = ADDR_W'(NUM_TONES);

    logic win_end;
    logic len_we;

    // Length register select.
    assign len_we = cfg_we && (cfg_addr == LEN_ADDR);

    lockin_window_ctl #(.CNT_W(CNT_W), .DEF_LEN(DEF_LEN)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .len_we    (len_we),
        .len_data  (cfg_wdata[CNT_W-1:0]),
        .win_end   (win_end)
    );

    for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
        logic                    f_we;
        logic signed [ACC_W-1:0] ti, tq;

        // Frequency word select for this tone.
        assign f_we = cfg_we && (cfg_addr == ADDR_W'(t));

        lockin_tone #(
            .SAMPLE_W (SAMPLE_W),
            .PHASE_W  (PHASE_W),
            .LUT_AW   (LUT_AW),
            .SINE_W   (SINE_W),
            .ACC_W    (ACC_W)
        ) u_tone (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .smp_data  (smp_data),
            .win_end   (win_end),
            .freq_we   (f_we),
            .freq_data (cfg_wdata),
            .res_i     (ti),
            .res_q     (tq),
            .res_valid (res_valid[t])
        );

        assign res_i[t*ACC_W +: ACC_W] = ti;
        assign res_q[t*ACC_W +: ACC_W] = tq;
    end
endmodule

// File: rtl/lockin_checker.sv
// Assertion checker for lockin_multitone, attached through bind.
// Watches only the top-level ports.
module lockin_checker #(
    parameter int NUM_TONES = 3,
    parameter int ACC_W     = 40
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       smp_valid,
    input logic [NUM_TONES*ACC_W-1:0] res_i,
    input logic [NUM_TONES*ACC_W-1:0] res_q,
    input logic [NUM_TONES-1:0]       res_valid
);
    // R1: a reset cycle leaves strobes and results cleared.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (res_valid == '0 && res_i == '0 && res_q == '0));

    // R5: a strobe only follows a cycle that accepted a sample.
    a_r5_valid_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid != '0) |-> $past(smp_valid));

    // R5: all tones dump together.
    a_r5_tones_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(res_valid) == 0) || ($countones(res_valid) == NUM_TONES));

    // R5: results hold between strobes.
    a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid == '0) |-> ($stable(res_i) && $stable(res_q)));
endmodule

bind lockin_multitone lockin_checker #(.NUM_TONES(NUM_TONES), .ACC_W(ACC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .res_i     (res_i),
    .res_q     (res_q),
    .res_valid (res_valid)
);

// File: tb/lockin_multitone_test.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared against a behavioural model built from the requirements.
module lockin_multitone_test;
    localparam int CLK_PERIOD = 10;
    localparam int NT = 3;
    localparam int AW = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [15:0] smp_data = '0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [NT*AW-1:0] res_i, res_q;
    logic [NT-1:0] res_valid;

    int checks = 0;
    int errors = 0;

    // Model state.
    logic [31:0] m_phase [NT];
    logic [31:0] m_freq  [NT];
    logic [31:0] m_pfreq [NT];
    bit          m_pend  [NT];
    logic signed [AW-1:0] m_ai [NT];
    logic signed [AW-1:0] m_aq [NT];
    logic signed [AW-1:0] e_i  [NT];
    logic signed [AW-1:0] e_q  [NT];
    int m_cnt, m_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    lockin_multitone uut (
        .clk, .rst_n, .smp_valid, .smp_data, .cfg_we, .cfg_addr, .cfg_wdata,
        .res_i, .res_q, .res_valid
    );

    // Reference value at a 10-bit phase index, rounded half away from zero.
    function automatic logic signed [15:0] ref_sin(int p);
        real x;
        x = 32767.0 * $sin(2.0 * 3.14159265358979323846 * (real'(p) + 0.5) / 1024.0);
        if (x >= 0.0) return 16'($rtoi(x + 0.5));
        return -16'($rtoi(-x + 0.5));
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            m_phase[t] = '0; m_freq[t] = '0; m_pfreq[t] = '0; m_pend[t] = 0;
            m_ai[t] = '0; m_aq[t] = '0; e_i[t] = '0; e_q[t] = '0;
        end
        m_cnt = 0; m_len = 16;
    endtask

    // Compare every tone's strobe and, on a dump, its sums.
    task automatic check_outputs(input bit dump, input string req);
        for (int t = 0; t < NT; t++) begin
            check(res_valid[t] == dump, "R5", "valid", 64'(res_valid[t]), 64'(dump));
            check(res_i[t*AW +: AW] == e_i[t], req, "I sum", 64'(res_i[t*AW +: AW]), 64'(e_i[t]));
            check(res_q[t*AW +: AW] == e_q[t], req, "Q sum", 64'(res_q[t*AW +: AW]), 64'(e_q[t]));
        end
    endtask

    // One accepted sample; called at a falling edge, returns at a falling edge.
    task automatic step(input logic signed [15:0] s, input string req);
        bit dump;
        logic signed [31:0] pi, pq;
        smp_valid = 1'b1; smp_data = s;
        @(posedge clk);
        dump = (m_cnt >= m_len - 1);
        for (int t = 0; t < NT; t++) begin
            pi = s * ref_sin((int'(m_phase[t][31:22]) + 256) % 1024);
            pq = s * ref_sin(int'(m_phase[t][31:22]));
            if (dump) begin
                e_i[t] = m_ai[t] + AW'(pi);
                e_q[t] = m_aq[t] + AW'(pq);
                m_ai[t] = '0; m_aq[t] = '0;
                if (m_pend[t]) begin
                    m_freq[t] = m_pfreq[t]; m_phase[t] = '0; m_pend[t] = 0;
                end else m_phase[t] = m_phase[t] + m_freq[t];
            end else begin
                m_ai[t] = m_ai[t] + AW'(pi);
                m_aq[t] = m_aq[t] + AW'(pq);
                m_phase[t] = m_phase[t] + m_freq[t];
            end
        end
        m_cnt = dump ? 0 : m_cnt + 1;
        @(negedge clk);
        smp_valid = 1'b0;
        check_outputs(dump, req);
    endtask

    // Cycle with no sample: no strobe, sums held (R5), phase frozen (R3).
    task automatic idle();
        @(posedge clk);
        @(negedge clk);
        check_outputs(1'b0, "R3");
    endtask

    task automatic cfg(input logic [1:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        if (a < 2'(NT)) begin
            m_pfreq[a] = d; m_pend[a] = 1;
        end else if (d[15:0] != 0) m_len = int'(d[15:0]);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic signed [15:0] rnd_smp();
        return 16'($urandom);
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all-requirements actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports.
        check(res_valid == '0, "R1", "valid after reset", 64'(res_valid), 0);
        check(res_i == '0 && res_q == '0, "R1", "sums after reset", 64'(res_i[63:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R4: default length 16, zero frequency.
        for (int k = 0; k < 16; k++) step(rnd_smp(), "R4");
        idle();

        // R6: words pend for the current window, then take over with phase zero.
        cfg(2'd0, 32'h5999999A);
        cfg(2'd1, 32'h4CCCCCCD);
        for (int k = 0; k < 8; k++) step(rnd_smp(), "R6");
        cfg(2'd2, 32'h0CCCCCCD);
        for (int k = 0; k < 8; k++) step(rnd_smp(), "R6");
        // R8: three tones at the aliased frequencies, R2 references.
        for (int k = 0; k < 32; k++) step(rnd_smp(), "R8");

        // R3: gaps between samples leave phase untouched.
        for (int k = 0; k < 48; k++) begin
            if ($urandom_range(0, 1) == 0) idle();
            step(rnd_smp(), "R3");
        end

        // R7: a zero length write is ignored.
        cfg(2'd3, 32'h0000_0000);
        for (int k = 0; k < 16; k++) step(rnd_smp(), "R7");

        // R9: length one dumps on every back-to-back sample.
        cfg(2'd3, 32'd1);
        for (int k = 0; k < 6; k++) step(rnd_smp(), "R9");

        // R7: shrinking below the running count ends the window on the next sample.
        cfg(2'd3, 32'd40);
        for (int k = 0; k < 10; k++) step(rnd_smp(), "R7");
        cfg(2'd3, 32'd4);
        step(rnd_smp(), "R7");
        for (int k = 0; k < 4; k++) step(rnd_smp(), "R7");

        // R4: full-scale window long enough to wrap 40 bits.
        cfg(2'd0, 32'd0);
        cfg(2'd3, 32'd3000);
        for (int k = 0; k < 3; k++) step(16'sh8000, "R4");
        for (int k = 0; k < 3000; k++) step(16'sh8000, "R4");

        // Random mix of lengths, mid-window frequency writes and gaps.
        for (int r = 0; r < 40; r++) begin
            cfg(2'd3, 32'($urandom_range(1, 50)));
            for (int k = 0; k < 60; k++) begin
                if ($urandom_range(0, 9) == 0) cfg(2'($urandom_range(0, NT-1)), $urandom);
                if ($urandom_range(0, 5) == 0) idle();
                step(rnd_smp(), "R8");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule